// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI shift engine from the core clock. An 8-bit divide code sets how many core cycles each half of the serial clock lasts, and the all-ones code selects the fastest setting. The clock polarity bit sets the level the serial clock rests at, and the phase bit decides which edge of each serial clock period is used to sample incoming data and which is used to drive outgoing data.

Besides the serial clock the block emits two single-cycle strobes, one for launching data and one for capturing it. Each strobe is aligned with the core cycle in which the matching serial clock edge first shows at the output. The shift engine therefore never has to decode edges itself. The block also holds the data-length field of the transfer format, stored as length minus one, and presents the length in bits. Polarity, phase, divide code and length are sampled on every idle cycle and are frozen for as long as a run lasts.

Top module: `sclk_divider`

## Requirements
- R1: While reset is held and in the first cycle after it, `sclk`, `busy`, `launch_stb` and `capture_stb` are all 0.
- R2: While `busy` is 0, `sclk` rests at the `cpol` value sampled on the previous core clock edge.
- R3: For a divide code d below 0xFF, each half of the serial clock period lasts d+1 core cycles, so the serial clock runs at the core rate divided by 2*(d+1). The leading edge appears d+1 cycles after the edge on which `run` is first seen high. This holds up to the largest true code, 0xFE.
- R4: Divide code 0xFF is the bypass code. In bypass, `sclk` changes level on every core cycle, and the launch and capture strobes alternate on successive cycles.
- R5: With `cpha`=0, `capture_stb` pulses with the leading (first) edge of each period and `launch_stb` pulses with the trailing (second) edge.
- R6: With `cpha`=1, `launch_stb` pulses with the leading edge and `capture_stb` pulses with the trailing edge.
- R7: Each strobe is high for exactly the one core cycle in which the new `sclk` level first appears. The two strobes are never high together, and while running `sclk` never changes without a strobe.
- R8: While `busy` is 1, changes on `div_code`, `cpol`, `cpha` and `len_code` are ignored. The run keeps its original timing, and `data_bits` keeps its value.
- R9: If `run` is low on a cycle where `sclk` is at its rest level, the block goes idle on the next edge without producing another edge. If `sclk` is at its active level, the block finishes the trailing edge and drops `busy` on that same edge.
- R10: `data_bits` equals `len_code`+1, the field being stored as length minus one. Code 7 gives 8 bits, 0 gives 1 bit and 31 gives 32 bits.
- R11: With `cpol`=1, all levels are inverted: `sclk` rests high, and the leading edge is a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Run enable from the shift engine |
| div_code | input | 8 | Half-period divide code, 0xFF = bypass |
| cpol | input | 1 | Clock polarity (rest level) |
| cpha | input | 1 | Clock phase (0: capture on leading edge) |
| len_code | input | 5 | Data length minus one |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle pulse with the launch edge |
| capture_stb | output | 1 | One-cycle pulse with the capture edge |
| busy | output | 1 | A run is in progress |
| data_bits | output | 6 | Data length in bits |

## Verification
Several properties are checked on every cycle:
- The rest level while idle.
- That the strobes never overlap.
- That `sclk` never moves without a strobe while running.
- The edge-to-strobe pairing for each phase setting.
- The counter bound.
- The early stop from the rest level.
- The frozen length during a run.

The exact half-period length and the position of the first edge can only be shown by the bench's scenarios. The same holds for the bypass alternation, the completion of a trailing edge on a late stop, and the immunity to mid-run configuration changes. The bench compares those cycle by cycle against a model.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;
    localparam int DEF_DIV_W = 8;
    localparam int DEF_LEN_W = 5;

    // Kind of serial clock edge produced on the last core clock edge
    typedef enum logic [1:0] {
        EDGE_NONE  = 2'd0,
        EDGE_LEAD  = 2'd1,
        EDGE_TRAIL = 2'd2
    } edge_e;
endpackage

// File: rtl/sclkdiv_cfg.sv
module sclkdiv_cfg
    import sclkdiv_pkg::*;
#(
    parameter int DIV_W = DEF_DIV_W,
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_code_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic [LEN_W-1:0] len_code_i,
    output logic             cpol_o,
    output logic             cpha_o,
    output logic [DIV_W-1:0] term_o,
    output logic [LEN_W:0]   data_bits_o
);
    localparam logic [DIV_W-1:0] BYPASS_CODE = {DIV_W{1'b1}};
    localparam logic [LEN_W-1:0] LEN_RESET   = LEN_W'(7);

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
        logic [LEN_W-1:0] len;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.cpol = cpol_i;
            cfg_d.cpha = cpha_i;
            cfg_d.div  = div_code_i;
            cfg_d.len  = len_code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{cpol: 1'b0, cpha: 1'b0, div: '0, len: LEN_RESET};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cpol_o      = cfg_q.cpol;
    assign cpha_o      = cfg_q.cpha;
    // bypass shares the one-cycle half period of the fastest registered clock
    assign term_o      = (cfg_q.div == BYPASS_CODE) ? '0 : cfg_q.div;
    assign data_bits_o = {1'b0, cfg_q.len} + {{LEN_W{1'b0}}, 1'b1};
endmodule

// File: rtl/sclkdiv_count.sv
module sclkdiv_count
    import sclkdiv_pkg::*;
#(
    parameter int DIV_W = DEF_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [DIV_W-1:0] term_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    assign tick_o = active_i && (cnt_q.cnt == term_i);

    always_comb begin
        cnt_d = cnt_q;
        if (!active_i || tick_o) begin
            cnt_d.cnt = '0;
        end else begin
            cnt_d.cnt = cnt_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // half period never exceeds the terminal count while running
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (cnt_q.cnt <= term_i));
endmodule

// File: rtl/sclkdiv_edge.sv
module sclkdiv_edge
    import sclkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic cpol_i,
    input  logic cpha_i,
    output logic active_o,
    output logic sclk_o,
    output logic launch_o,
    output logic capture_o
);
    typedef struct packed {
        logic  active;
        logic  phase;
        edge_e kind;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kind = EDGE_NONE;
        if (!st_q.active) begin
            st_d.phase = 1'b0;
            st_d.active = run_i;
        end else if (!run_i && !st_q.phase) begin
            st_d.active = 1'b0;
        end else if (tick_i) begin
            st_d.phase = ~st_q.phase;
            if (!st_q.phase) begin
                st_d.kind = EDGE_LEAD;
            end else begin
                st_d.kind = EDGE_TRAIL;
                st_d.active = run_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, phase: 1'b0, kind: EDGE_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o  = st_q.active;
    assign sclk_o    = cpol_i ^ st_q.phase;
    assign launch_o  = (st_q.kind == (cpha_i ? EDGE_LEAD : EDGE_TRAIL));
    assign capture_o = (st_q.kind == (cpha_i ? EDGE_TRAIL : EDGE_LEAD));

    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> (sclk_o == cpol_i));

    assert_cpha0_capture_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_o && !cpha_i) |-> (sclk_o != cpol_i));

    assert_cpha1_capture_trail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_o && cpha_i) |-> (sclk_o == cpol_i));

    assert_early_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !run_i && !st_q.phase) |=> (!st_q.active && st_q.kind == EDGE_NONE));
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
    import sclkdiv_pkg::*;
#(
    parameter int DIV_W = DEF_DIV_W,
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [LEN_W-1:0] len_code,
    output logic             sclk,
    output logic             launch_stb,
    output logic             capture_stb,
    output logic             busy,
    output logic [LEN_W:0]   data_bits
);
    logic             cfg_cpol, cfg_cpha, tick;
    logic [DIV_W-1:0] term;

    sclkdiv_cfg #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (!busy),
        .div_code_i  (div_code),
        .cpol_i      (cpol),
        .cpha_i      (cpha),
        .len_code_i  (len_code),
        .cpol_o      (cfg_cpol),
        .cpha_o      (cfg_cpha),
        .term_o      (term),
        .data_bits_o (data_bits)
    );

    sclkdiv_count #(.DIV_W(DIV_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (busy),
        .term_i   (term),
        .tick_o   (tick)
    );

    sclkdiv_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .tick_i    (tick),
        .cpol_i    (cfg_cpol),
        .cpha_i    (cfg_cpha),
        .active_o  (busy),
        .sclk_o    (sclk),
        .launch_o  (launch_stb),
        .capture_o (capture_stb)
    );

    assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_stb && capture_stb));

    assert_edge_has_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (sclk != $past(sclk))) |-> (launch_stb || capture_stb));

    assert_len_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(data_bits));
endmodule

// File: tb/sclk_divider_test.sv
`timescale 1ns/1ps
module sclk_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [7:0] div_code = 8'd0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic [4:0] len_code = 5'd7;
    logic       sclk, launch_stb, capture_stb, busy;
    logic [5:0] data_bits;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sclk_divider uut (
        .clk(clk), .rst_n(rst_n), .run(run), .div_code(div_code),
        .cpol(cpol), .cpha(cpha), .len_code(len_code),
        .sclk(sclk), .launch_stb(launch_stb), .capture_stb(capture_stb),
        .busy(busy), .data_bits(data_bits)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check4(input string tag, input int k, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: {busy,sclk,launch,capture} actual %b expected %b", tag, k, act, exp);
        end
    endtask

    task automatic check_bits(input string tag, input logic [5:0] exp);
        checks++;
        if (data_bits !== exp) begin
            fails++;
            $display("FAIL %s: data_bits actual %0d expected %0d", tag, data_bits, exp);
        end
    endtask

    // model: edges counted from the edge on which run is first seen high
    function automatic logic [3:0] model(input int k, input int h, input logic p, input logic ph, input logic bz);
        int t;
        logic edg, lead, trail;
        t = k / h;
        edg = (k > 0) && (k % h == 0);
        lead = edg && (t % 2 == 1);
        trail = edg && (t % 2 == 0);
        return {bz, p ^ logic'(t % 2), ph ? lead : trail, ph ? trail : lead};
    endfunction

    task automatic test_reset();
        check4("R1 during reset", 0, {busy, sclk, launch_stb, capture_stb}, 4'b0000);
        rst_n = 1'b1;
        step();
        check4("R1 after reset", 0, {busy, sclk, launch_stb, capture_stb}, 4'b0000);
        check_bits("R10 reset length", 6'd8);
    endtask

    task automatic test_idle();
        cpol = 1'b1; len_code = 5'd0;
        step();
        check4("R2 idle high", 0, {busy, sclk, launch_stb, capture_stb}, 4'b0100);
        check_bits("R10 code 0", 6'd1);
        cpol = 1'b0; len_code = 5'd31;
        step();
        check4("R2 idle low", 0, {busy, sclk, launch_stb, capture_stb}, 4'b0000);
        check_bits("R10 code 31", 6'd32);
        len_code = 5'd7;
        step();
        check_bits("R10 code 7", 6'd8);
    endtask

    task automatic run_pattern(input string tag, input logic [7:0] d, input logic p, input logic ph,
                               input int n, input logic scramble);
        int h;
        logic [5:0] bits_exp;
        h = (d == 8'hFF) ? 1 : int'(d) + 1;
        div_code = d; cpol = p; cpha = ph; len_code = 5'd11;
        bits_exp = 6'd12;
        step();
        step();
        run = 1'b1;
        for (int k = 0; k <= n; k++) begin
            step();
            check4(tag, k, {busy, sclk, launch_stb, capture_stb}, model(k, h, p, ph, 1'b1));
            if (scramble && k == 2) begin
                div_code = d ^ 8'h05; cpol = ~p; cpha = ~ph; len_code = 5'd3;
            end
        end
        if (scramble) check_bits("R8 length held", bits_exp);
        run = 1'b0;
        if ((n / h) % 2 == 0) begin
            step();
            check4("R9 stop at rest", n + 1, {busy, sclk, launch_stb, capture_stb}, {1'b0, p, 2'b00});
        end else begin
            for (int k = n + 1; k <= (n / h + 1) * h; k++) begin
                step();
                check4("R9 finish trailing", k, {busy, sclk, launch_stb, capture_stb},
                       model(k, h, p, ph, k != (n / h + 1) * h));
            end
        end
        cpol = 1'b0; cpha = 1'b0;
        step();
        step();
    endtask

    initial begin
        step();
        step();
        test_reset();
        test_idle();
        run_pattern("R3 R5 div3 mode0", 8'd3, 1'b0, 1'b0, 24, 1'b0);
        run_pattern("R6 R9 div3 mode1", 8'd3, 1'b0, 1'b1, 22, 1'b0);
        run_pattern("R4 R11 bypass cpol1", 8'hFF, 1'b1, 1'b0, 9, 1'b0);
        run_pattern("R4 bypass mode3", 8'hFF, 1'b1, 1'b1, 12, 1'b0);
        run_pattern("R3 R11 div0 mode3", 8'd0, 1'b1, 1'b1, 10, 1'b0);
        run_pattern("R8 scrambled inputs", 8'd2, 1'b0, 1'b0, 15, 1'b1);
        run_pattern("R3 R6 div 0xFE", 8'hFE, 1'b0, 1'b1, 600, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule